// File: doc/BRIEF.md
# Dual-Destination Forwarding Select

This combinational unit chooses where each operand of a five-stage pipeline gets its value from. In this pipeline one instruction may write two registers: a low destination written by ordinary results and a high destination written only by a multiply. The unit compares the register numbers read by the instruction in execute with the low and high destinations held in the EX/MEM and MEM/WB pipeline registers. For each of the two ALU operands it emits a select that tells the operand mux which value to take.

A second, smaller path serves the memory stage. The instruction in memory may take its store data register, or its address register, from the result now in write-back. This lets a load followed at once by a store of the loaded register complete without a stall.

The datapath muxes and the pipeline registers sit outside this unit. Only register numbers and write enables come in, and only encoded selects go out.

Top module: `fwd_select`

## Requirements
- R1: The ALU operand A select uses the code 0 for the register file, 1 for EX/MEM low, 2 for EX/MEM high, 3 for MEM/WB low and 4 for MEM/WB high. When several candidates match, the code chosen is the lowest non-zero code that matches.
- R2: The ALU operand B select follows the same encoding and priority as R1, judged on operand B's register number alone and independently of operand A.
- R3: A candidate whose write enable is low never drives a select, even if its register number matches.
- R4: When no enabled candidate matches an operand, that operand's select is 0 (register file).
- R5: The MEM/WB candidates are matched against the MEM/WB destination numbers. An EX/MEM number equal to the operand does not produce code 3 or 4.
- R6: The store-data select is 1 when MEM/WB low is enabled and equals the memory stage's data register. Otherwise it is 2 when MEM/WB high is enabled and matches that register. Otherwise it is 0.
- R7: The store-address select follows the rule of R6, with the match made on the memory stage's address register.
- R8: The store-data and store-address selects resolve independently in the same cycle. A single MEM/WB load destination that names both registers drives both selects to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_a_idx | input | 3 | register number of ALU operand A in execute |
| ex_b_idx | input | 3 | register number of ALU operand B in execute |
| exm_lo_we | input | 1 | EX/MEM low destination write enable |
| exm_lo_idx | input | 3 | EX/MEM low destination number |
| exm_hi_we | input | 1 | EX/MEM high destination write enable |
| exm_hi_idx | input | 3 | EX/MEM high destination number |
| mwb_lo_we | input | 1 | MEM/WB low destination write enable |
| mwb_lo_idx | input | 3 | MEM/WB low destination number |
| mwb_hi_we | input | 1 | MEM/WB high destination write enable |
| mwb_hi_idx | input | 3 | MEM/WB high destination number |
| mem_data_idx | input | 3 | store data register of the memory-stage instruction |
| mem_addr_idx | input | 3 | address register of the memory-stage instruction |
| alu_a_sel | output | 3 | operand A select, codes as in R1 |
| alu_b_sel | output | 3 | operand B select, codes as in R1 |
| mem_data_sel | output | 2 | store data select, codes as in R6 |
| mem_addr_sel | output | 2 | store address select, codes as in R7 |

## Verification
Two things can happen in the same evaluation. The two ALU operands may resolve against different candidates, and the memory-stage data and address paths may both hit on one write-back destination. Random stimulus drawn from a narrow range of register numbers makes such overlaps common. Directed cases force all four destinations to one number, and force a load result that names both store registers. Every output is compared with a priority model in the bench, so a wrong rank or a cross-wired path shows up as a mismatch.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int NUM_REGS = 8
) (
  input  logic [$clog2(NUM_REGS)-1:0] ex_a_idx,
  input  logic [$clog2(NUM_REGS)-1:0] ex_b_idx,
  input  logic                        exm_lo_we,
  input  logic [$clog2(NUM_REGS)-1:0] exm_lo_idx,
  input  logic                        exm_hi_we,
  input  logic [$clog2(NUM_REGS)-1:0] exm_hi_idx,
  input  logic                        mwb_lo_we,
  input  logic [$clog2(NUM_REGS)-1:0] mwb_lo_idx,
  input  logic                        mwb_hi_we,
  input  logic [$clog2(NUM_REGS)-1:0] mwb_hi_idx,
  input  logic [$clog2(NUM_REGS)-1:0] mem_data_idx,
  input  logic [$clog2(NUM_REGS)-1:0] mem_addr_idx,
  output logic [2:0]                  alu_a_sel,
  output logic [2:0]                  alu_b_sel,
  output logic [1:0]                  mem_data_sel,
  output logic [1:0]                  mem_addr_sel
);
  localparam int IW = $clog2(NUM_REGS);

  function automatic logic [2:0] alu_pick(input logic [IW-1:0] src,
      input logic elw, input logic [IW-1:0] eli,
      input logic ehw, input logic [IW-1:0] ehi,
      input logic mlw, input logic [IW-1:0] mli,
      input logic mhw, input logic [IW-1:0] mhi);
    if (elw && eli == src)      return 3'd1;
    else if (ehw && ehi == src) return 3'd2;
    else if (mlw && mli == src) return 3'd3;
    else if (mhw && mhi == src) return 3'd4;
    else                        return 3'd0;
  endfunction

  function automatic logic [1:0] mem_pick(input logic [IW-1:0] reg_idx,
      input logic mlw, input logic [IW-1:0] mli,
      input logic mhw, input logic [IW-1:0] mhi);
    if (mlw && mli == reg_idx)      return 2'd1;
    else if (mhw && mhi == reg_idx) return 2'd2;
    else                            return 2'd0;
  endfunction

  assign alu_a_sel = alu_pick(ex_a_idx, exm_lo_we, exm_lo_idx, exm_hi_we, exm_hi_idx,
                              mwb_lo_we, mwb_lo_idx, mwb_hi_we, mwb_hi_idx);
  assign alu_b_sel = alu_pick(ex_b_idx, exm_lo_we, exm_lo_idx, exm_hi_we, exm_hi_idx,
                              mwb_lo_we, mwb_lo_idx, mwb_hi_we, mwb_hi_idx);

  assign mem_data_sel = mem_pick(mem_data_idx, mwb_lo_we, mwb_lo_idx, mwb_hi_we, mwb_hi_idx);
  assign mem_addr_sel = mem_pick(mem_addr_idx, mwb_lo_we, mwb_lo_idx, mwb_hi_we, mwb_hi_idx);
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int IW = 3
) (
  input logic [IW-1:0] ex_a_idx,
  input logic [IW-1:0] ex_b_idx,
  input logic          exm_lo_we,
  input logic [IW-1:0] exm_lo_idx,
  input logic          exm_hi_we,
  input logic [IW-1:0] exm_hi_idx,
  input logic          mwb_lo_we,
  input logic [IW-1:0] mwb_lo_idx,
  input logic          mwb_hi_we,
  input logic [IW-1:0] mwb_hi_idx,
  input logic [IW-1:0] mem_data_idx,
  input logic [IW-1:0] mem_addr_idx,
  input logic [2:0]    alu_a_sel,
  input logic [2:0]    alu_b_sel,
  input logic [1:0]    mem_data_sel,
  input logic [1:0]    mem_addr_sel
);
  always_comb begin
    AST_A_RANGE: assert (alu_a_sel <= 3'd4);  // R1
    AST_A_TOP_RANK: assert (!(exm_lo_we && exm_lo_idx == ex_a_idx) || alu_a_sel == 3'd1);  // R1
    AST_B_TOP_RANK: assert (!(exm_lo_we && exm_lo_idx == ex_b_idx) || alu_b_sel == 3'd1);  // R2
    AST_GATED_LO: assert (exm_lo_we || (alu_a_sel != 3'd1 && alu_b_sel != 3'd1));  // R3
    AST_GATED_HI: assert (mwb_hi_we || (alu_a_sel != 3'd4 && mem_data_sel != 2'd2));  // R3
    AST_NO_MATCH_RF: assert (!(!(exm_lo_we && exm_lo_idx == ex_a_idx) && !(exm_hi_we && exm_hi_idx == ex_a_idx)
                              && !(mwb_lo_we && mwb_lo_idx == ex_a_idx) && !(mwb_hi_we && mwb_hi_idx == ex_a_idx))
                              || alu_a_sel == 3'd0);  // R4
    AST_WB_INDEX: assert (alu_a_sel != 3'd3 || mwb_lo_idx == ex_a_idx);  // R5
    AST_DATA_LO: assert (!(mwb_lo_we && mwb_lo_idx == mem_data_idx) || mem_data_sel == 2'd1);  // R6
    AST_ADDR_LO: assert (!(mwb_lo_we && mwb_lo_idx == mem_addr_idx) || mem_addr_sel == 2'd1);  // R7
    AST_SHARED_HIT: assert (!(mem_data_idx == mem_addr_idx) || mem_data_sel == mem_addr_sel);  // R8
  end
endmodule

bind fwd_select fwd_select_chk #(.IW(IW)) u_chk (.*);

// File: tb/fwd_select_tb.sv
module fwd_select_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [2:0] a_idx, b_idx, eli, ehi, mli, mhi, d_idx, ad_idx;
  logic elw, ehw, mlw, mhw;
  logic [2:0] a_sel, b_sel;
  logic [1:0] d_sel, ad_sel;
  int errors = 0;
  int checks = 0;

  fwd_select u_dut (
    .ex_a_idx(a_idx), .ex_b_idx(b_idx),
    .exm_lo_we(elw), .exm_lo_idx(eli), .exm_hi_we(ehw), .exm_hi_idx(ehi),
    .mwb_lo_we(mlw), .mwb_lo_idx(mli), .mwb_hi_we(mhw), .mwb_hi_idx(mhi),
    .mem_data_idx(d_idx), .mem_addr_idx(ad_idx),
    .alu_a_sel(a_sel), .alu_b_sel(b_sel), .mem_data_sel(d_sel), .mem_addr_sel(ad_sel));

  function automatic logic [2:0] ref_alu(input logic [2:0] s);
    logic [2:0] r = 3'd0;
    if (mhw && mhi == s) r = 3'd4;
    if (mlw && mli == s) r = 3'd3;
    if (ehw && ehi == s) r = 3'd2;
    if (elw && eli == s) r = 3'd1;
    return r;
  endfunction

  function automatic logic [1:0] ref_mem(input logic [2:0] s);
    logic [1:0] r = 2'd0;
    if (mhw && mhi == s) r = 2'd2;
    if (mlw && mli == s) r = 2'd1;
    return r;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_and_check(input string note);
    @(negedge clk);
    #1;
    chk({"R1/R2 operand A ", note}, a_sel, ref_alu(a_idx));
    chk({"R2 operand B ", note}, b_sel, ref_alu(b_idx));
    chk({"R6 store data ", note}, d_sel, ref_mem(d_idx));
    chk({"R7 store address ", note}, ad_sel, ref_mem(ad_idx));
  endtask

  task automatic set_all(input logic [2:0] a, input logic [2:0] b,
      input logic w0, input logic [2:0] i0, input logic w1, input logic [2:0] i1,
      input logic w2, input logic [2:0] i2, input logic w3, input logic [2:0] i3,
      input logic [2:0] d, input logic [2:0] ad);
    a_idx = a; b_idx = b; elw = w0; eli = i0; ehw = w1; ehi = i1;
    mlw = w2; mli = i2; mhw = w3; mhi = i3; d_idx = d; ad_idx = ad;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seed = 17;
    void'($urandom(seed));
    // R4: idle state, nothing enabled
    set_all(3'd1, 3'd2, 0, 1, 0, 2, 0, 1, 0, 2, 3'd1, 3'd2);
    @(negedge clk); #1;
    chk("R4 idle A", a_sel, 0); chk("R4 idle B", b_sel, 0);
    chk("R4 idle data", d_sel, 0); chk("R4 idle addr", ad_sel, 0);
    // R1: all four name r5, top rank wins
    set_all(3'd5, 3'd5, 1, 5, 1, 5, 1, 5, 1, 5, 3'd5, 3'd5);
    @(negedge clk); #1;
    chk("R1 all match", a_sel, 1); chk("R2 all match", b_sel, 1);
    // R3: disabled EX/MEM low drops to EX/MEM high
    elw = 1'b0;
    @(negedge clk); #1;
    chk("R3 gated low", a_sel, 2);
    ehw = 1'b0; mlw = 1'b0;
    @(negedge clk); #1;
    chk("R1 only MEM/WB high", a_sel, 4);
    chk("R6 high only data", d_sel, 2);
    // R5: EX/MEM numbers equal operand but disabled; MEM/WB numbers differ
    set_all(3'd3, 3'd6, 0, 3, 0, 3, 1, 6, 1, 2, 3'd0, 3'd0);
    @(negedge clk); #1;
    chk("R5 no false hit A", a_sel, 0); chk("R5 hit B via MEM/WB low", b_sel, 3);
    // R8: load result names both store registers
    set_all(3'd0, 3'd0, 0, 0, 0, 0, 1, 4, 1, 4, 3'd4, 3'd4);
    @(negedge clk); #1;
    chk("R8 data", d_sel, 1); chk("R8 addr", ad_sel, 1);
    // R7: address hits high while data hits low
    set_all(3'd0, 3'd0, 0, 0, 0, 0, 1, 2, 1, 7, 3'd2, 3'd7);
    @(negedge clk); #1;
    chk("R7 addr high", ad_sel, 2); chk("R6 data low", d_sel, 1);
    for (int n = 0; n < 400; n++) begin
      set_all(3'($urandom_range(0, 3)), 3'($urandom_range(0, 3)),
              1'($urandom), 3'($urandom_range(0, 3)), 1'($urandom), 3'($urandom_range(0, 3)),
              1'($urandom), 3'($urandom_range(0, 3)), 1'($urandom), 3'($urandom_range(0, 3)),
              3'($urandom_range(0, 3)), 3'($urandom_range(0, 3)));
      apply_and_check("random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule